// File: doc/BRIEF.md
# Divide-by-Three Clock Generator with Balanced Duty

This block takes a free-running input clock and produces a clock at one third of its frequency. The output's high phase and low phase are the same length: one and a half input periods each. A 50 MHz input therefore gives a 16.67 MHz output with equal halves. An odd ratio cannot give equal halves from one clock edge alone, so the block uses both edges of the input clock.

A three-state phase machine runs on the rising edge. Its states are `PH0`, `PH1` and `PH2`, and it moves through the transitions `PH0->PH1`, `PH1->PH2` and `PH2->PH0`. The machine has a registered marker that is high for the one input period after it leaves `PH0`. A second register captures that marker on the following falling edge, half a period later. The output is the OR of these two registered signals. No decoded state bits reach the output, so it has no combinational hazard. An active-low asynchronous reset clears the machine and both registers, and the output stays low while reset is held.

The balanced duty depends on the input clock having equal halves. The block is placed next to the source clock and feeds downstream logic that needs a slower symmetric clock.

Top module: `clkdiv3_even_duty`

## Requirements
- R1: While `rst_n` is low, `div_clk` is 0. Asserting `rst_n` forces `div_clk` low at once, with no input clock edge needed.
- R2: After `rst_n` is released, `div_clk` rises on the first rising edge of `clk_in`.
- R3: The phase machine cycles `PH0->PH1->PH2->PH0` on rising edges. As a result, consecutive rising edges of `div_clk` are exactly three `clk_in` periods apart.
- R4: Each high phase of `div_clk` lasts exactly 1.5 `clk_in` periods, and so does each low phase.
- R5: `div_clk` rises only at a rising edge of `clk_in` and falls only at a falling edge of `clk_in`. It makes at most one transition per input half-period, so it has no glitches.
- R6: Asserting `rst_n` in the middle of a run restarts the sequence. After release, the output follows the same timing as R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; both edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_clk | output | 1 | Divided clock, frequency `clk_in`/3, balanced duty |

## Verification
Let rising edge k be the k-th rising edge of `clk_in` after reset release. In the half-period after rising edge k, `div_clk` is due high when k mod 3 is 1 or 2. In the half-period after the falling edge that follows, it is due high only when k mod 3 is 1. The bench derives these values from an edge counter and compares the output 2 ns into every half-period, well away from both edges. Separate monitors time-stamp each `div_clk` edge to measure the period and the high time, and to check that each edge lines up with the matching `clk_in` edge. The reset check samples 1 ns after `rst_n` falls, between clock edges, which confirms that the clear does not wait for a clock edge.

// File: rtl/clkdiv3_pkg.sv
package clkdiv3_pkg;

    // Phase of the rising-edge sequencer
    typedef enum logic [1:0] {
        PH0 = 2'd0,
        PH1 = 2'd1,
        PH2 = 2'd2
    } phase_t;

endpackage

// File: rtl/clkdiv3_phase_fsm.sv
module clkdiv3_phase_fsm
    import clkdiv3_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase,
    output logic   rise_q
);

    phase_t phase_nxt;
    logic   rise_nxt;

    // Next-state decode
    always_comb begin
        phase_nxt = PH0;
        unique case (phase)
            PH0:     phase_nxt = PH1;
            PH1:     phase_nxt = PH2;
            PH2:     phase_nxt = PH0;
            default: phase_nxt = PH0;
        endcase
    end

    // Marker output decode: high for the period after leaving PH0
    always_comb begin
        rise_nxt = 1'b0;
        unique case (phase)
            PH0:     rise_nxt = 1'b1;
            PH1:     rise_nxt = 1'b0;
            PH2:     rise_nxt = 1'b0;
            default: rise_nxt = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH0;
        else        phase <= phase_nxt;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= rise_nxt;
    end

endmodule

// File: rtl/clkdiv3_fall_stage.sv
module clkdiv3_fall_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // Captures d half an input period later
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end

endmodule

// File: rtl/clkdiv3_even_duty.sv
module clkdiv3_even_duty
    import clkdiv3_pkg::*;
(
    input  logic clk_in,
    input  logic rst_n,
    output logic div_clk
);

    phase_t phase;
    logic   rise_q;
    logic   fall_q;

    clkdiv3_phase_fsm u_fsm (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .phase  (phase),
        .rise_q (rise_q)
    );

    clkdiv3_fall_stage u_fall (
        .clk   (clk_in),
        .rst_n (rst_n),
        .d     (rise_q),
        .q     (fall_q)
    );

    // Both inputs are flops; the OR has no hazard between them
    assign div_clk = rise_q | fall_q;

endmodule

// File: rtl/clkdiv3_even_duty_chk.sv
module clkdiv3_even_duty_chk
    import clkdiv3_pkg::*;
(
    input logic   clk_in,
    input logic   rst_n,
    input phase_t phase,
    input logic   rise_q,
    input logic   fall_q,
    input logic   div_clk
);

    assert_reset_low_R1: assert property (@(posedge clk_in)
        !rst_n |-> !div_clk);

    assert_ph0_to_ph1_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase == PH0) |=> (phase == PH1));

    assert_ph1_to_ph2_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase == PH1) |=> (phase == PH2));

    assert_ph2_to_ph0_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase == PH2) |=> (phase == PH0));

    assert_marker_single_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
        rise_q |=> !rise_q);

    assert_fall_follows_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        fall_q == rise_q);

endmodule

bind clkdiv3_even_duty clkdiv3_even_duty_chk u_chk (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .phase   (phase),
    .rise_q  (rise_q),
    .fall_q  (fall_q),
    .div_clk (div_clk)
);

// File: tb/clkdiv3_even_duty_tb_top.sv
`timescale 1ns/1ps
module clkdiv3_even_duty_tb_top;

    logic clk_in = 1'b0;
    logic rst_n  = 1'b0;
    logic div_clk;

    int checks = 0;
    int errors = 0;
    int k      = 0;
    bit meas_en   = 0;
    bit have_rise = 0;
    bit done      = 0;
    realtime last_rise = 0.0;
    realtime t_pos = 0.0;
    realtime t_neg = 0.0;

    always #4 clk_in = ~clk_in;   // 125 MHz

    clkdiv3_even_duty dut_i (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .div_clk (div_clk)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t",
                     req, what, actual, expected, $realtime);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk_in) t_pos = $realtime;
    always @(negedge clk_in) t_neg = $realtime;

    // Reference model: k = rising edges since release
    initial begin
        forever begin
            @(posedge clk_in);
            if (rst_n) k++;
            else       k = 0;
            #2;
            check(div_clk === ((rst_n && (k % 3 == 1 || k % 3 == 2)) ? 1'b1 : 1'b0),
                  "R3", "first-half level", int'(div_clk),
                  (rst_n && (k % 3 == 1 || k % 3 == 2)) ? 1 : 0);
            @(negedge clk_in);
            #2;
            check(div_clk === ((rst_n && k % 3 == 1) ? 1'b1 : 1'b0),
                  "R4", "second-half level", int'(div_clk),
                  (rst_n && k % 3 == 1) ? 1 : 0);
        end
    end

    // Period and high-time measurement (times in ps)
    always @(posedge div_clk) begin
        if (meas_en && have_rise)
            check(int'(($realtime - last_rise) * 1000.0) == 24000, "R3", "period ps",
                  int'(($realtime - last_rise) * 1000.0), 24000);
        last_rise = $realtime;
        have_rise = meas_en;
    end

    always @(negedge div_clk) begin
        if (meas_en && have_rise)
            check(int'(($realtime - last_rise) * 1000.0) == 12000, "R4", "high time ps",
                  int'(($realtime - last_rise) * 1000.0), 12000);
    end

    // Edge alignment monitors
    always @(posedge div_clk) begin
        if (rst_n) begin
            #0.5;
            check(clk_in == 1'b1 && ($realtime - t_pos) < 1.0, "R5",
                  "rise aligned to clk rise", int'(clk_in), 1);
        end
    end

    always @(negedge div_clk) begin
        if (rst_n) begin
            #0.5;
            check(clk_in == 1'b0 && ($realtime - t_neg) < 1.0, "R5",
                  "fall aligned to clk fall", int'(clk_in), 0);
        end
    end

    initial begin
        #3;
        check(div_clk === 1'b0, "R1", "low in reset", int'(div_clk), 0);
        #27;                          // t=30, second half after rise at 28
        rst_n = 1'b1;
        @(posedge clk_in);
        #1;
        check(div_clk === 1'b1, "R2", "rise on first clk edge", int'(div_clk), 1);
        meas_en = 1;
        repeat (360) @(posedge clk_in);
        meas_en = 0;
        // Mid-run reset in the first half of a high phase
        wait (div_clk == 1'b1);
        #1;
        rst_n = 1'b0;
        #1;
        check(div_clk === 1'b0, "R1", "async clear", int'(div_clk), 0);
        repeat (5) @(posedge clk_in);
        #1;
        check(div_clk === 1'b0, "R1", "held low in reset", int'(div_clk), 0);
        @(negedge clk_in);
        #1;
        rst_n = 1'b1;
        @(posedge clk_in);
        #1;
        check(div_clk === 1'b1, "R6", "restart rise", int'(div_clk), 1);
        have_rise = 0;
        meas_en = 1;
        repeat (330) @(posedge clk_in);
        meas_en = 0;
        #3;
        finish_run();
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule